// File: doc/BRIEF.md
# Strip Coincidence Trigger Logic

This block sits behind the discriminators of a stacked pair of strip sensors. The upper sensor has long strips. The lower sensor has short strips, and a fixed group of consecutive short strips lies under each long strip. Every channel first passes through a test-injection OR and then a mask. A long strip forms a coincidence when it fires together with any short strip of its own group. Three fast flags report whether anything fired in the upper layer, in the lower layer, or as a coincidence. Trigger logic uses these flags to pick out stiff tracks without a full readout.

For slower inspection, a single load pulse freezes the conditioned upper hits, the coincidence bits and the lower hits into shift registers. The shift enable then clocks them out serially, most significant bit first. Upper hits and coincidences each use one line. The lower hits are split into four lanes. Each lower strip becomes an 8-bit word that holds its hit bit and its position within the lane, so every lane is self-describing.

Top module: `strip_coinc_trigger`

## Requirements
- R1: A long strip's conditioned hit is (hit OR inject) AND NOT mask, with mask bit 1 meaning the channel is off. A masked strip appears in no flag, coincidence or serial bit.
- R2: Short strips are conditioned by the same rule as long strips in R1, each with its own inject and mask bit.
- R3: Coincidence bit i is set exactly when conditioned long strip i is set and at least one conditioned short strip in the range 5i to 5i+4 is set.
- R4: `or_long` equals the OR of all conditioned long hits sampled at the previous clock edge (one register of latency).
- R5: `or_short` equals the OR of all conditioned short hits at the previous clock edge.
- R6: `or_coinc` equals the OR of all coincidence bits at the previous clock edge.
- R7: After a clock edge with `load` high, `ser_long` shows conditioned long strip 63. Each later edge with `shift` high advances to the next lower strip. After strip 0 has been shown, zeros follow.
- R8: `ser_coinc` presents the 64 coincidence bits with the same load and shift timing as R7, starting at bit 63.
- R9: Lane k of `ser_short` carries short strips 80k to 80k+79, one 8-bit word each, starting at lane-local index 79 and counting down. Each word is sent MSB first: bit 7 is the conditioned hit and bits 6..0 are the lane-local index. Zeros follow the last word.
- R10: Changes of hit, inject or mask inputs after a load do not alter the bits being shifted out.
- R11: When `load` and `shift` are both high at an edge, the load wins and the stream restarts from its first bit with fresh data.
- R12: Synchronous active-high reset clears all three flags and all serial outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| long_hit | input | 64 | Discriminated long-strip hits |
| long_inj | input | 64 | Long-strip test injection |
| long_mask | input | 64 | Long-strip mask, 1 = off |
| short_hit | input | 320 | Discriminated short-strip hits |
| short_inj | input | 320 | Short-strip test injection |
| short_mask | input | 320 | Short-strip mask, 1 = off |
| load | input | 1 | Capture maps into shift registers |
| shift | input | 1 | Advance serial streams by one bit |
| or_long | output | 1 | Fast OR of long strips |
| or_coinc | output | 1 | Fast OR of coincidences |
| or_short | output | 1 | Fast OR of short strips |
| ser_long | output | 1 | Serial long-strip map |
| ser_coinc | output | 1 | Serial coincidence map |
| ser_short | output | 4 | Serial short-strip word lanes |

## Verification
The assertions check on every cycle that each fast flag follows the OR of its conditioned set one edge later, and that no coincidence exists without its long strip. They also check that the first serial bit after a load is the top long strip, and that the first bit of lane 0 is the top short strip of that lane. The group mapping of each long strip to its five short strips cannot be shown by these assertions; a bench sweep over every strip and group offset, with neighbour-group negatives, shows it. The same applies to the complete word layout of each lane, the immunity of a stream to input changes mid-readout, and load priority; the bench shows these with full readouts.

// File: rtl/scl_pkg.sv
package scl_pkg;
    localparam int DEF_N_LONG = 64;
    localparam int DEF_GROUP  = 5;
    localparam int DEF_LANES  = 4;
    localparam int DEF_WORD_W = 8;

    typedef struct packed {
        logic long_any;
        logic coinc_any;
        logic short_any;
    } fast_or_t;

    function automatic int idx_bits(input int n);
        int b;
        b = 1;
        while ((1 << b) < n) b++;
        return b;
    endfunction
endpackage

// File: rtl/scl_hit_cond.sv
module scl_hit_cond #(
    parameter int W = 64
) (
    input  logic [W-1:0] hit,
    input  logic [W-1:0] inj,
    input  logic [W-1:0] mask,
    output logic [W-1:0] eff
);
    // injection joins the hit path before the mask gates it
    always_comb eff = (hit | inj) & ~mask;
endmodule

// File: rtl/scl_coinc.sv
module scl_coinc
    import scl_pkg::*;
#(
    parameter int N_LONG = DEF_N_LONG,
    parameter int GROUP  = DEF_GROUP
) (
    input  logic [N_LONG-1:0]       eff_long,
    input  logic [N_LONG*GROUP-1:0] eff_short,
    output logic [N_LONG-1:0]       coinc,
    output fast_or_t                any
);
    logic [N_LONG-1:0] grp_or;

    for (genvar i = 0; i < N_LONG; i++) begin : g_grp
        assign grp_or[i] = |eff_short[i*GROUP +: GROUP];
        assign coinc[i]  = eff_long[i] & grp_or[i];
    end

    always_comb begin
        any.long_any  = |eff_long;
        any.coinc_any = |coinc;
        any.short_any = |grp_or;
    end
endmodule

// File: rtl/scl_shreg.sv
module scl_shreg #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] din,
    output logic         sout
);
    logic [W-1:0] q;

    always_ff @(posedge clk) begin
        if (rst)        q <= '0;
        else if (load)  q <= din;
        else if (shift) q <= {q[W-2:0], 1'b0};
    end

    assign sout = q[W-1];
endmodule

// File: rtl/strip_coinc_trigger.sv
module strip_coinc_trigger
    import scl_pkg::*;
#(
    parameter int N_LONG = DEF_N_LONG,
    parameter int GROUP  = DEF_GROUP,
    parameter int LANES  = DEF_LANES,
    parameter int WORD_W = DEF_WORD_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N_LONG-1:0]       long_hit,
    input  logic [N_LONG-1:0]       long_inj,
    input  logic [N_LONG-1:0]       long_mask,
    input  logic [N_LONG*GROUP-1:0] short_hit,
    input  logic [N_LONG*GROUP-1:0] short_inj,
    input  logic [N_LONG*GROUP-1:0] short_mask,
    input  logic                    load,
    input  logic                    shift,
    output logic                    or_long,
    output logic                    or_coinc,
    output logic                    or_short,
    output logic                    ser_long,
    output logic                    ser_coinc,
    output logic [LANES-1:0]        ser_short
);
    localparam int N_SHORT = N_LONG * GROUP;
    localparam int SPL     = N_SHORT / LANES;
    localparam int IDX_W   = WORD_W - 1;
    localparam int LANE_W  = SPL * WORD_W;

    logic [N_LONG-1:0]  eff_long;
    logic [N_SHORT-1:0] eff_short;
    logic [N_LONG-1:0]  coinc;
    fast_or_t           any_now;
    fast_or_t           any_q;

    scl_hit_cond #(.W(N_LONG)) u_cond_long (
        .hit(long_hit), .inj(long_inj), .mask(long_mask), .eff(eff_long)
    );

    scl_hit_cond #(.W(N_SHORT)) u_cond_short (
        .hit(short_hit), .inj(short_inj), .mask(short_mask), .eff(eff_short)
    );

    scl_coinc #(.N_LONG(N_LONG), .GROUP(GROUP)) u_coinc (
        .eff_long(eff_long), .eff_short(eff_short), .coinc(coinc), .any(any_now)
    );

    always_ff @(posedge clk) begin
        if (rst) any_q <= '0;
        else     any_q <= any_now;
    end

    assign or_long  = any_q.long_any;
    assign or_coinc = any_q.coinc_any;
    assign or_short = any_q.short_any;

    scl_shreg #(.W(N_LONG)) u_sr_long (
        .clk(clk), .rst(rst), .load(load), .shift(shift),
        .din(eff_long), .sout(ser_long)
    );

    scl_shreg #(.W(N_LONG)) u_sr_coinc (
        .clk(clk), .rst(rst), .load(load), .shift(shift),
        .din(coinc), .sout(ser_coinc)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [LANE_W-1:0] lane_din;
        for (genvar j = 0; j < SPL; j++) begin : g_word
            assign lane_din[j*WORD_W +: WORD_W] = {eff_short[k*SPL + j], IDX_W'(j)};
        end
        scl_shreg #(.W(LANE_W)) u_sr_short (
            .clk(clk), .rst(rst), .load(load), .shift(shift),
            .din(lane_din), .sout(ser_short[k])
        );
    end
endmodule

// File: rtl/strip_coinc_trigger_chk.sv
module strip_coinc_trigger_chk #(
    parameter int N_LONG = 64,
    parameter int GROUP  = 5,
    parameter int LANES  = 4
) (
    input logic                    clk,
    input logic                    rst,
    input logic [N_LONG-1:0]       long_hit,
    input logic [N_LONG-1:0]       long_inj,
    input logic [N_LONG-1:0]       long_mask,
    input logic [N_LONG*GROUP-1:0] short_hit,
    input logic [N_LONG*GROUP-1:0] short_inj,
    input logic [N_LONG*GROUP-1:0] short_mask,
    input logic                    load,
    input logic                    or_long,
    input logic                    or_coinc,
    input logic                    or_short,
    input logic                    ser_long,
    input logic [LANES-1:0]        ser_short,
    input logic [N_LONG-1:0]       coinc
);
    localparam int SPL = N_LONG * GROUP / LANES;

    AST_OR_LONG_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> or_long == $past(|((long_hit | long_inj) & ~long_mask))); // R4
    AST_OR_SHORT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> or_short == $past(|((short_hit | short_inj) & ~short_mask))); // R5
    AST_OR_COINC_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> or_coinc == $past(|coinc)); // R6
    AST_COINC_NEEDS_LONG: assert property (@(posedge clk) disable iff (rst)
        (coinc & ~((long_hit | long_inj) & ~long_mask)) == '0); // R3
    AST_LOAD_LONG_TOP: assert property (@(posedge clk) disable iff (rst)
        load |=> ser_long == $past((long_hit[N_LONG-1] | long_inj[N_LONG-1]) & ~long_mask[N_LONG-1])); // R7
    AST_LOAD_LANE0_TOP: assert property (@(posedge clk) disable iff (rst)
        load |=> ser_short[0] == $past((short_hit[SPL-1] | short_inj[SPL-1]) & ~short_mask[SPL-1])); // R9
endmodule

bind strip_coinc_trigger strip_coinc_trigger_chk #(
    .N_LONG(N_LONG), .GROUP(GROUP), .LANES(LANES)
) u_chk (
    .clk(clk), .rst(rst),
    .long_hit(long_hit), .long_inj(long_inj), .long_mask(long_mask),
    .short_hit(short_hit), .short_inj(short_inj), .short_mask(short_mask),
    .load(load), .or_long(or_long), .or_coinc(or_coinc), .or_short(or_short),
    .ser_long(ser_long), .ser_short(ser_short), .coinc(coinc)
);

// File: tb/sim_strip_coinc_trigger.sv
module sim_strip_coinc_trigger;
    localparam int CLK_PERIOD = 10;
    localparam int NL = 64;
    localparam int GR = 5;
    localparam int NS = NL * GR;
    localparam int LN = 4;
    localparam int SPL = NS / LN;
    localparam int LANE_BITS = SPL * 8;

    logic clk = 0;
    logic rst = 1;
    logic [NL-1:0] long_hit = '0, long_inj = '0, long_mask = '0;
    logic [NS-1:0] short_hit = '0, short_inj = '0, short_mask = '0;
    logic load = 0, shift = 0;
    logic or_long, or_coinc, or_short, ser_long, ser_coinc;
    logic [LN-1:0] ser_short;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    strip_coinc_trigger u0 (
        .clk(clk), .rst(rst),
        .long_hit(long_hit), .long_inj(long_inj), .long_mask(long_mask),
        .short_hit(short_hit), .short_inj(short_inj), .short_mask(short_mask),
        .load(load), .shift(shift),
        .or_long(or_long), .or_coinc(or_coinc), .or_short(or_short),
        .ser_long(ser_long), .ser_coinc(ser_coinc), .ser_short(ser_short)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [NL-1:0] effl();
        return (long_hit | long_inj) & ~long_mask;
    endfunction

    function automatic logic [NS-1:0] effs();
        return (short_hit | short_inj) & ~short_mask;
    endfunction

    function automatic logic [NL-1:0] model_coinc(input logic [NL-1:0] l, input logic [NS-1:0] s);
        logic [NL-1:0] c;
        for (int i = 0; i < NL; i++) begin
            c[i] = 1'b0;
            for (int o = 0; o < GR; o++) c[i] = c[i] | (l[i] & s[i*GR + o]);
        end
        return c;
    endfunction

    function automatic logic [NS-1:0] rnd_s();
        logic [NS-1:0] v;
        for (int i = 0; i < NS; i += 32) v[i +: 32] = $urandom;
        return v;
    endfunction

    function automatic logic [NL-1:0] rnd_l();
        return {$urandom, $urandom};
    endfunction

    // word j of lane k: bit7 hit, bits6..0 = j; words from j=79 down, MSB first
    function automatic bit exp_lane(input int k, input int n, input logic [NS-1:0] s);
        int j, b;
        if (n >= LANE_BITS) return 1'b0;
        j = SPL - 1 - n / 8;
        b = 7 - n % 8;
        if (b == 7) return s[k*SPL + j];
        return ((j >> b) & 1) != 0;
    endfunction

    task automatic check_flags(input string tag);
        logic [NL-1:0] l;
        logic [NS-1:0] s;
        l = effl();
        s = effs();
        @(posedge clk);
        @(negedge clk);
        chk(or_long == |l, {"R4 or_long ", tag}, int'(or_long), int'(|l));
        chk(or_short == |s, {"R5 or_short ", tag}, int'(or_short), int'(|s));
        chk(or_coinc == |model_coinc(l, s), {"R6 or_coinc ", tag}, int'(or_coinc), int'(|model_coinc(l, s)));
    endtask

    // perturb: change inputs mid-stream (R10); reload_at: load+shift together (R11)
    task automatic readout(input string tag, input bit perturb, input int reload_at);
        logic [NL-1:0] l, c;
        logic [NS-1:0] s;
        int n;
        l = effl(); s = effs(); c = model_coinc(l, s);
        load = 1; shift = 0;
        @(posedge clk);
        @(negedge clk);
        load = 0; shift = 1;
        n = 0;
        for (int t = 0; t < LANE_BITS + 3; t++) begin
            chk(ser_long == ((n < NL) ? l[NL-1-n] : 1'b0), {"R7 ser_long ", tag}, int'(ser_long), n);
            chk(ser_coinc == ((n < NL) ? c[NL-1-n] : 1'b0), {"R8 ser_coinc ", tag}, int'(ser_coinc), n);
            for (int k = 0; k < LN; k++)
                chk(ser_short[k] == exp_lane(k, n, s), {"R9 ser_short ", tag}, int'(ser_short[k]), int'(exp_lane(k, n, s)));
            if (perturb && t == 3) begin
                long_hit = ~long_hit; short_hit = ~short_hit; long_mask = '0; short_mask = '0; // R10
            end
            if (t == reload_at) begin
                long_hit = rnd_l(); short_hit = rnd_s();
                l = effl(); s = effs(); c = model_coinc(l, s);
                load = 1; // R11: with shift still high
                n = -1;
            end else begin
                load = 0;
            end
            n++;
            @(posedge clk);
            @(negedge clk);
        end
        shift = 0;
    endtask

    task automatic clear_in();
        long_hit = '0; long_inj = '0; long_mask = '0;
        short_hit = '0; short_inj = '0; short_mask = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(or_long == 0 && or_coinc == 0 && or_short == 0, "R12 flags in reset", int'({or_long, or_coinc, or_short}), 0);
        chk(ser_long == 0 && ser_coinc == 0 && ser_short == 0, "R12 serial in reset", int'({ser_long, ser_coinc, ser_short}), 0);
        rst = 0;
        check_flags("idle");

        // R1 R2: raw random hits
        long_hit = rnd_l(); short_hit = rnd_s();
        check_flags("random");
        readout("random", 1'b0, -1);

        // R1 R2: injection only
        clear_in(); long_inj = rnd_l(); short_inj = rnd_s();
        check_flags("inject");
        readout("inject", 1'b0, -1);

        // R1 R2: everything on but fully masked
        long_hit = '1; short_hit = '1; long_mask = '1; short_mask = '1;
        check_flags("masked all");
        readout("masked all", 1'b0, -1);

        // R1: single long strip masked, its group active
        clear_in(); long_hit[7] = 1; long_mask[7] = 1; short_hit[35] = 1;
        @(posedge clk); @(negedge clk);
        chk(or_long == 0, "R1 single mask long", int'(or_long), 0);
        chk(or_coinc == 0, "R1 single mask coinc", int'(or_coinc), 0);
        chk(or_short == 1, "R2 short unmasked", int'(or_short), 1);

        // R2: short mask on the only short hit kills coincidence
        clear_in(); long_hit[7] = 1; short_hit[35] = 1; short_mask[35] = 1;
        @(posedge clk); @(negedge clk);
        chk(or_coinc == 0 && or_short == 0, "R2 single mask short", int'({or_coinc, or_short}), 0);

        // R1 R2: random masks and injections
        long_hit = rnd_l(); short_hit = rnd_s(); long_inj = rnd_l(); short_inj = rnd_s();
        long_mask = rnd_l(); short_mask = rnd_s();
        check_flags("mixed");
        readout("mixed", 1'b0, -1);

        // R3: sweep each long strip with each group offset, plus neighbour negatives
        for (int i = 0; i < NL; i++) begin
            for (int o = 0; o < GR; o++) begin
                clear_in(); long_hit[i] = 1; short_hit[i*GR + o] = 1;
                @(posedge clk); @(negedge clk);
                chk(or_coinc == 1, "R3 own group", int'(or_coinc), 1);
                clear_in(); long_hit[i] = 1; short_hit[((i + 1) % NL)*GR + o] = 1;
                @(posedge clk); @(negedge clk);
                chk(or_coinc == 0, "R3 neighbour group", int'(or_coinc), 0);
            end
        end

        // R3 R8: dense coincidence map
        clear_in(); long_hit = rnd_l(); short_hit = rnd_s() & rnd_s() & rnd_s();
        readout("coinc map", 1'b0, -1);

        // R10: inputs change while shifting
        clear_in(); long_hit = rnd_l(); short_hit = rnd_s(); long_mask = rnd_l();
        readout("frozen", 1'b1, -1);

        // R11: load with shift restarts the stream
        clear_in(); long_hit = rnd_l(); short_hit = rnd_s();
        readout("reload", 1'b0, 10);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int cyc = 0; cyc < 150000; cyc++) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule